// File: doc/BRIEF.md
# Bayer White-Balance Gain Stage

This block scales a raw Bayer pixel stream by two gains in cascade: a per-colour white-balance gain and an overall digital gain. Every pixel arrives with a valid flag and frame-start and line-start markers. A small position tracker follows each pixel's row and column parity. A programmable 2x2 pattern word maps that parity to one of the four Bayer components (R, Gr, Gb, B), and the gain of that component is applied.

The two gains use different fixed-point formats. The product is rounded to the nearest integer and clipped to the pixel width. The stage accepts one pixel per clock and has a fixed three-cycle latency. The valid flag and the markers travel alongside the data. Each pixel captures all gains and the pattern word in the same cycle as the pixel itself, so values that change from pixel to pixel are applied to the right pixel.

The position tracker is a state machine whose state is the tile position of the last accepted pixel. It has five states:
- `ST_IDLE`: no pixel seen since reset.
- `ST_R0C0`, `ST_R0C1`, `ST_R1C0`, `ST_R1C1`: row parity and column parity of the last accepted pixel.

A valid pixel selects one of three transitions:
- frame-start: go to `ST_R0C0`.
- line-start: invert the row parity and set the column parity to 0.
- plain pixel: invert the column parity. From `ST_IDLE` a plain pixel goes to `ST_R0C0`.

Invalid cycles hold the state.

Top module: `wb_gain_stage`

## Requirements
- R1: While reset is held and after its release, `out_valid`, `out_sof` and `out_sol` are 0 until valid input has passed through the pipeline.
- R2: `out_valid` equals `in_valid` from three clock cycles earlier. `out_sof` equals `in_sof & in_valid` from three cycles earlier, and `out_sol` equals `in_sol & in_valid` from three cycles earlier.
- R3: `cfa_pattern` holds a 2-bit code for each tile position at bits [2*i+1:2*i], with i = {row parity, column parity}. Code 0 selects `gain_r`, 1 selects `gain_gr`, 2 selects `gain_gb` and 3 selects `gain_b`.
- R4: A valid pixel with `in_sof` is at row 0, column 0. A valid pixel with `in_sol` only is at column 0, with its row parity inverted from the previous pixel. Any other valid pixel inverts the previous column parity. The first valid pixel after reset is at row 0, column 0. Invalid cycles do not move the position.
- R5: For a valid pixel, `out_pix` = min(16383, floor((pix * wbgain * dgain + 16384) / 32768)). Here wbgain is the unsigned selected component gain with 7 fraction bits, and dgain is `gain_global`, unsigned with 8 fraction bits.
- R6: With `gain_global` = 256 (x1.0) and a component gain of 128 (x1.0), the output equals the input pixel.
- R7: A global gain of 0 or a selected component gain of 0 gives an output of 0.
- R8: Results above 16383 saturate to 16383. This includes the maximum gains 1023/1023 applied to pixel 16383.
- R9: The gains and the pattern word presented in the same cycle as a pixel are the ones applied to that pixel, even when they change on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_pix | input | 14 | Raw pixel |
| cfa_pattern | input | 8 | 2x2 component map, 2 bits per position |
| gain_global | input | 10 | Global gain, 8 fraction bits |
| gain_r | input | 10 | Red gain, 7 fraction bits |
| gain_gr | input | 10 | Green-on-red-row gain, 7 fraction bits |
| gain_gb | input | 10 | Green-on-blue-row gain, 7 fraction bits |
| gain_b | input | 10 | Blue gain, 7 fraction bits |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Frame start marker, delayed |
| out_sol | output | 1 | Line start marker, delayed |
| out_pix | output | 14 | Scaled pixel |

## Verification
The checker watches three things on every cycle:
- the three-cycle alignment of the valid flag and the markers;
- zero in gives zero out;
- an input passes through unchanged when both gains are unity.

Only the bench scenarios can show the rest. These are the parity tracking across frames, lines and gaps, and the mapping of each pattern code to the right component gain. They also cover rounding and saturation over random operands, and gains that change on every pixel.

// File: rtl/wb_pkg.sv
package wb_pkg;
    localparam int PIX_W   = 14;
    localparam int DG_W    = 10;
    localparam int DG_FRAC = 8;
    localparam int WB_W    = 10;
    localparam int WB_FRAC = 7;
    localparam int N_COMP  = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_R0C0 = 3'd1,
        ST_R0C1 = 3'd2,
        ST_R1C0 = 3'd3,
        ST_R1C1 = 3'd4
    } pos_state_t;

    typedef enum logic [1:0] {
        CMP_R  = 2'd0,
        CMP_GR = 2'd1,
        CMP_GB = 2'd2,
        CMP_B  = 2'd3
    } comp_t;

    typedef struct packed {
        logic valid;
        logic sof;
        logic sol;
    } side_t;
endpackage

// File: rtl/wb_pos_fsm.sv
module wb_pos_fsm
    import wb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_sol,
    output logic cur_row,
    output logic cur_col
);
    pos_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // position of the current pixel and next state
    always_comb begin
        logic prev_row, prev_col;
        prev_row = 1'b0;
        prev_col = 1'b1;
        unique case (state_q)
            ST_IDLE: begin prev_row = 1'b0; prev_col = 1'b1; end
            ST_R0C0: begin prev_row = 1'b0; prev_col = 1'b0; end
            ST_R0C1: begin prev_row = 1'b0; prev_col = 1'b1; end
            ST_R1C0: begin prev_row = 1'b1; prev_col = 1'b0; end
            ST_R1C1: begin prev_row = 1'b1; prev_col = 1'b1; end
            default: begin prev_row = 1'b0; prev_col = 1'b1; end
        endcase

        if (in_sof || state_q == ST_IDLE) begin
            cur_row = 1'b0;
            cur_col = 1'b0;
        end else if (in_sol) begin
            cur_row = ~prev_row;
            cur_col = 1'b0;
        end else begin
            cur_row = prev_row;
            cur_col = ~prev_col;
        end

        state_d = state_q;
        if (in_valid) begin
            unique case ({cur_row, cur_col})
                2'b00: state_d = ST_R0C0;
                2'b01: state_d = ST_R0C1;
                2'b10: state_d = ST_R1C0;
                2'b11: state_d = ST_R1C1;
                default: state_d = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wb_cfa_select.sv
module wb_cfa_select
    import wb_pkg::*;
#(
    parameter int GW = WB_W
) (
    input  logic [2*N_COMP-1:0]     pattern,
    input  logic                    row,
    input  logic                    col,
    input  logic [N_COMP*GW-1:0]    gains,
    output logic [GW-1:0]           gain_sel
);
    localparam int CODE_W = $clog2(N_COMP);

    logic [CODE_W-1:0] code;
    logic [GW-1:0]     gain_arr [N_COMP];

    genvar gi;
    generate
        for (gi = 0; gi < N_COMP; gi++) begin : g_unpack
            assign gain_arr[gi] = gains[gi*GW +: GW];
        end
    endgenerate

    always_comb begin
        code     = pattern[{row, col}*CODE_W +: CODE_W];
        gain_sel = gain_arr[code];
    end
endmodule

// File: rtl/wb_gain_mul.sv
module wb_gain_mul
    import wb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIX_W-1:0]   s1_pix,
    input  logic [WB_W-1:0]    s1_wb,
    input  logic [DG_W-1:0]    s1_dg,
    input  side_t              s1_side,
    output logic [PIX_W-1:0]   out_pix,
    output side_t              out_side
);
    localparam int P1_W   = PIX_W + WB_W;
    localparam int P2_W   = P1_W + DG_W + 1;
    localparam int SHIFT  = DG_FRAC + WB_FRAC;
    localparam logic [P2_W-1:0] HALF = P2_W'(1) << (SHIFT - 1);
    localparam logic [P2_W-1:0] MAXV = P2_W'((1 << PIX_W) - 1);

    logic [P1_W-1:0] s2_prod;
    logic [DG_W-1:0] s2_dg;
    side_t           s2_side;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_prod <= '0;
            s2_dg   <= '0;
            s2_side <= '0;
        end else begin
            s2_prod <= P1_W'(s1_pix) * P1_W'(s1_wb);
            s2_dg   <= s1_dg;
            s2_side <= s1_side;
        end
    end

    logic [P2_W-1:0] full, scaled;
    always_comb begin
        full   = P2_W'(s2_prod) * P2_W'(s2_dg) + HALF;
        scaled = full >> SHIFT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_pix  <= '0;
            out_side <= '0;
        end else begin
            out_pix  <= (scaled > MAXV) ? MAXV[PIX_W-1:0] : scaled[PIX_W-1:0];
            out_side <= s2_side;
        end
    end
endmodule

// File: rtl/wb_gain_stage.sv
module wb_gain_stage
    import wb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [13:0]       in_pix,
    input  logic [7:0]        cfa_pattern,
    input  logic [9:0]        gain_global,
    input  logic [9:0]        gain_r,
    input  logic [9:0]        gain_gr,
    input  logic [9:0]        gain_gb,
    input  logic [9:0]        gain_b,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_sol,
    output logic [13:0]       out_pix
);
    logic row, col;
    logic [WB_W-1:0] wb_sel;

    wb_pos_fsm u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_sol   (in_sol),
        .cur_row  (row),
        .cur_col  (col)
    );

    wb_cfa_select #(.GW(WB_W)) u_sel (
        .pattern  (cfa_pattern),
        .row      (row),
        .col      (col),
        .gains    ({gain_b, gain_gb, gain_gr, gain_r}),
        .gain_sel (wb_sel)
    );

    logic [PIX_W-1:0] s1_pix;
    logic [WB_W-1:0]  s1_wb;
    logic [DG_W-1:0]  s1_dg;
    side_t            s1_side;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_pix  <= '0;
            s1_wb   <= '0;
            s1_dg   <= '0;
            s1_side <= '0;
        end else begin
            s1_pix        <= in_pix;
            s1_wb         <= wb_sel;
            s1_dg         <= gain_global;
            s1_side.valid <= in_valid;
            s1_side.sof   <= in_sof & in_valid;
            s1_side.sol   <= in_sol & in_valid;
        end
    end

    side_t o_side;

    wb_gain_mul u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_pix   (s1_pix),
        .s1_wb    (s1_wb),
        .s1_dg    (s1_dg),
        .s1_side  (s1_side),
        .out_pix  (out_pix),
        .out_side (o_side)
    );

    assign out_valid = o_side.valid;
    assign out_sof   = o_side.sof;
    assign out_sol   = o_side.sol;
endmodule

// File: rtl/wb_gain_chk.sv
module wb_gain_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_sof,
    input logic        in_sol,
    input logic [13:0] in_pix,
    input logic [9:0]  gain_global,
    input logic [9:0]  gain_r,
    input logic [9:0]  gain_gr,
    input logic [9:0]  gain_gb,
    input logic [9:0]  gain_b,
    input logic        out_valid,
    input logic        out_sof,
    input logic        out_sol,
    input logic [13:0] out_pix
);
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
    logic warm;
    assign warm = (since_rst == 2'd3);

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 3)));

    // R2
    marker_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_sof == ($past(in_sof, 3) && $past(in_valid, 3)) &&
                  out_sol == ($past(in_sol, 3) && $past(in_valid, 3))));

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !warm |-> (!out_sof && !out_sol));

    // R7
    zero_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(gain_global, 3) == 10'd0) |-> (out_pix == 14'd0));

    // R6
    unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(gain_global, 3) == 10'd256 &&
         $past(gain_r, 3) == 10'd128 && $past(gain_gr, 3) == 10'd128 &&
         $past(gain_gb, 3) == 10'd128 && $past(gain_b, 3) == 10'd128)
        |-> (out_pix == $past(in_pix, 3)));
endmodule

bind wb_gain_stage wb_gain_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .in_sol      (in_sol),
    .in_pix      (in_pix),
    .gain_global (gain_global),
    .gain_r      (gain_r),
    .gain_gr     (gain_gr),
    .gain_gb     (gain_gb),
    .gain_b      (gain_b),
    .out_valid   (out_valid),
    .out_sof     (out_sof),
    .out_sol     (out_sol),
    .out_pix     (out_pix)
);

// File: tb/wb_gain_stage_bench.sv
module wb_gain_stage_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        in_valid = 0, in_sof = 0, in_sol = 0;
    logic [13:0] in_pix = 0;
    logic [7:0]  cfa_pattern = 0;
    logic [9:0]  gain_global = 0, gain_r = 0, gain_gr = 0, gain_gb = 0, gain_b = 0;
    logic        out_valid, out_sof, out_sol;
    logic [13:0] out_pix;

    wb_gain_stage u_wb_gain_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
        .in_pix(in_pix), .cfa_pattern(cfa_pattern), .gain_global(gain_global),
        .gain_r(gain_r), .gain_gr(gain_gr), .gain_gb(gain_gb), .gain_b(gain_b),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol), .out_pix(out_pix)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // next-cycle stimulus values
    logic [7:0] t_pat = 8'h1B;
    logic [9:0] t_dg = 10'd256, t_r = 10'd128, t_gr = 10'd128, t_gb = 10'd128, t_b = 10'd128;

    // expected pipeline: [2] is the oldest
    logic        e_v [3];
    logic        e_f [3];
    logic        e_l [3];
    logic [13:0] e_p [3];
    string       e_tag [3];

    // bench position model (R4)
    bit m_started = 0;
    bit m_row = 0, m_col = 0;

    function automatic logic [13:0] model_out(input logic [13:0] p, input logic [9:0] wb,
                                              input logic [9:0] dg);
        longint prod;
        prod = (longint'(p) * longint'(wb) * longint'(dg) + 64'd16384) >>> 15;
        if (prod > 16383) prod = 16383;
        return 14'(prod);
    endfunction

    task automatic check_out();
        n_checks++;
        if (out_valid !== e_v[2] || out_sof !== e_f[2] || out_sol !== e_l[2]) begin
            n_fail++;
            $display("FAIL R2 valid/sof/sol actual %b%b%b expected %b%b%b",
                     out_valid, out_sof, out_sol, e_v[2], e_f[2], e_l[2]);
        end
        if (e_v[2]) begin
            n_checks++;
            if (out_pix !== e_p[2]) begin
                n_fail++;
                $display("FAIL %s out_pix actual %0d expected %0d", e_tag[2], out_pix, e_p[2]);
            end
        end
    endtask

    task automatic cycle(input logic v, input logic f, input logic l,
                         input logic [13:0] p, input string tag);
        logic r, c;
        logic [1:0] code;
        logic [9:0] wb;
        @(negedge clk);
        check_out();
        in_valid = v; in_sof = f; in_sol = l; in_pix = p;
        cfa_pattern = t_pat; gain_global = t_dg;
        gain_r = t_r; gain_gr = t_gr; gain_gb = t_gb; gain_b = t_b;
        if (f || !m_started) begin r = 0; c = 0; end
        else if (l)          begin r = ~m_row; c = 0; end
        else                 begin r = m_row; c = ~m_col; end
        if (v) begin m_started = 1; m_row = r; m_col = c; end
        code = t_pat[{r, c}*2 +: 2];
        case (code)
            2'd0: wb = t_r;
            2'd1: wb = t_gr;
            2'd2: wb = t_gb;
            default: wb = t_b;
        endcase
        for (int k = 2; k > 0; k--) begin
            e_v[k] = e_v[k-1]; e_f[k] = e_f[k-1]; e_l[k] = e_l[k-1];
            e_p[k] = e_p[k-1]; e_tag[k] = e_tag[k-1];
        end
        e_v[0] = v; e_f[0] = f & v; e_l[0] = l & v;
        e_p[0] = model_out(p, wb, t_dg); e_tag[0] = tag;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3; k++) begin
            e_v[k] = 0; e_f[k] = 0; e_l[k] = 0; e_p[k] = 0; e_tag[k] = "R1";
        end
        repeat (4) @(posedge clk);
        // R1: outputs idle during reset
        @(negedge clk);
        n_checks++;
        if (out_valid !== 0 || out_sof !== 0 || out_sol !== 0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual %b%b%b expected 000", out_valid, out_sof, out_sol);
        end
        rst_n = 1;
        repeat (3) cycle(0, 0, 0, 14'd0, "R1");

        // R6: unity gains pass the pixel through; first pixel after reset is row0 col0 (R4)
        t_pat = 8'hE4; t_dg = 256; t_r = 128; t_gr = 128; t_gb = 128; t_b = 128;
        cycle(1, 0, 0, 14'd1234, "R6");
        cycle(1, 1, 0, 14'd0, "R6");
        cycle(1, 0, 0, 14'd16383, "R6");
        cycle(1, 0, 1, 14'd7, "R6");

        // R7: zero global gain, then zero component gain
        t_dg = 0; t_r = 500; t_gr = 500; t_gb = 500; t_b = 500;
        cycle(1, 1, 0, 14'd9000, "R7");
        cycle(1, 0, 0, 14'd16383, "R7");
        t_dg = 1000; t_r = 0; t_gr = 0; t_gb = 0; t_b = 0;
        cycle(1, 0, 1, 14'd12000, "R7");
        cycle(1, 0, 0, 14'd5, "R7");

        // R8: saturation at maximum gains
        t_dg = 1023; t_r = 1023; t_gr = 1023; t_gb = 1023; t_b = 1023;
        cycle(1, 1, 0, 14'd16383, "R8");
        cycle(1, 0, 0, 14'd3000, "R8");
        cycle(1, 0, 0, 14'd1, "R8");

        // R3/R4: distinct gains expose the chosen component per position, with gaps
        t_dg = 256; t_r = 128; t_gr = 256; t_gb = 384; t_b = 512;
        for (int pat = 0; pat < 4; pat++) begin
            t_pat = (pat == 0) ? 8'hE4 : (pat == 1) ? 8'h1B : (pat == 2) ? 8'h4E : 8'hB1;
            for (int ln = 0; ln < 3; ln++) begin
                for (int px = 0; px < 5; px++) begin
                    cycle(1, (ln == 0 && px == 0), (px == 0), 14'd1000 + 14'(px), "R3/R4");
                    if (px == 2) cycle(0, 0, 0, 14'd0, "R4");
                end
            end
        end

        // R5/R9: random pixels, gains, pattern and markers changing every cycle
        for (int i = 0; i < 3000; i++) begin
            logic v, f, l;
            t_pat = 8'($urandom); t_dg = 10'($urandom); t_r = 10'($urandom);
            t_gr = 10'($urandom); t_gb = 10'($urandom); t_b = 10'($urandom);
            if (($urandom % 4) == 0) begin t_dg = 256; t_r = 128; end
            v = ($urandom % 5) != 0;
            f = ($urandom % 40) == 0;
            l = ($urandom % 8) == 0;
            cycle(v, f, l, 14'($urandom), (i % 2) ? "R5" : "R9");
        end

        repeat (4) cycle(0, 0, 0, 14'd0, "R2");
        finish_run();
    end
endmodule